// File: doc/BRIEF.md
# Flash busy-status flag generator

This block produces the status byte that a NOR-style flash memory returns while one of its internal program or erase algorithms runs. It watches the bus strobes: rising edges of the write strobe, qualified by chip enable, count the pulses of a command sequence. A read access is the start of a cycle in which chip enable and output enable are both low. The block tracks a small operation state: program, erase, the sector-erase acceptance window, erase suspend, the fake busy time shown for protected targets, and the exceeded-limit failure.

While an operation is in progress, every read returns a status byte instead of array data. This byte carries a toggle flag that inverts on each new read access, a flag set when the internal pulse count passes its limit, and a flag that reports whether the erase has really started. When the block is idle, reads pass the array data input through unchanged. All durations are parameters in clock cycles. A second output lists the sectors being erased, so the effect of sector protection can be seen.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the block is idle: `busy` is 0, `erase_mask` is 0 and `dout` equals `array_data`.
- R2: A program starts on the 4th qualified write-strobe rising edge (`we_n` 0 to 1 while `ce_n` is low) with `cmd_op`=1 held. `busy` rises one clock after that edge and not after the 3rd. `cmd_op` of 0 or 7 clears the pulse count.
- R3: A chip erase (`cmd_op`=2) or a sector erase (`cmd_op`=3) starts on the 6th qualified write-strobe rising edge and not earlier.
- R4: While busy, each new read access (a cycle where `ce_n` and `oe_n` are both low after a cycle where they were not both low, whichever of the two fell) inverts `dout[6]`. With no new access, `dout[6]` holds.
- R5: When idle, `dout` equals `array_data`.
- R6: While busy, `dout` bit 6 is the toggle, bit 5 is exceeded-limit, bit 3 is erase-started, and bits 7, 4, 2, 1 and 0 are 0.
- R7: Programming a sector whose `prot_mask` bit is set stays busy for PROT_PROG_CYCLES clocks, then returns to idle with bit 5 never set.
- R8: A chip erase, or the end of a sector-erase window, erases only the selected unprotected sectors, as shown on `erase_mask`. If all selected sectors are protected, the block stays busy for PROT_ERASE_CYCLES clocks with `erase_mask` 0, then returns to idle.
- R9: If the operation timer reaches `pulse_limit` before completion, `dout[5]` reads 1. The block then stays busy, with the toggle still active, until a reset command. A program with `cmd_blank`=0 never completes.
- R10: A sector erase first opens an acceptance window of ACCEPT_CYCLES clocks with `dout[3]`=0. Each further `cmd_op`=3 pulse in the window adds `cmd_sector` and restarts the window. Once erasing, `dout[3]`=1 and further sector pulses have no effect on `erase_mask`.
- R11: During an erase, a `cmd_op`=4 pulse suspends it: the block stays busy, the toggle stays active and the timer freezes. A `cmd_op`=5 pulse resumes the erase.
- R12: A `cmd_op`=6 pulse returns the block to idle one clock after the edge, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| cmd_op | input | 3 | Decoded command: 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume, 6 reset, 0/7 none |
| cmd_sector | input | $clog2(NUM_SECTORS) | Target sector of the command |
| cmd_blank | input | 1 | Program target is blank |
| prot_mask | input | NUM_SECTORS | Per-sector protection |
| pulse_limit | input | LIM_W | Internal pulse-count limit in clocks |
| array_data | input | 8 | Array read data for idle reads |
| dout | output | 8 | Read data or status byte |
| busy | output | 1 | An operation is in progress |
| erase_mask | output | NUM_SECTORS | Sectors currently being erased |

## Verification
The bench targets the pulse-count boundaries, the protection cases and the failure lock. It checks that a program does not start on the 3rd pulse or an erase on the 5th, which a miscounting counter would do. It also checks that a read started by chip enable inverts the toggle just like one started by output enable. It adds a sector late in the window and then adds one after the erase has begun. A window that failed to restart, or that kept accepting sectors, would show the wrong `erase_mask`. It confirms that a protected program never raises the exceeded flag, that an all-protected erase drops back to idle after its fake time, and that a failed program stays busy until a reset command, which a design without a sticky failure would not do.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int NUM_SECTORS       = 8,
  parameter int LIM_W             = 16,
  parameter int PROG_CYCLES       = 1000,
  parameter int ERASE_CYCLES      = 50000,
  parameter int PROT_PROG_CYCLES  = 250,
  parameter int PROT_ERASE_CYCLES = 25000,
  parameter int ACCEPT_CYCLES     = 6250
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_n,
  input  logic                   oe_n,
  input  logic                   we_n,
  input  logic [2:0]             cmd_op,
  input  logic [$clog2(NUM_SECTORS)-1:0] cmd_sector,
  input  logic                   cmd_blank,
  input  logic [NUM_SECTORS-1:0] prot_mask,
  input  logic [LIM_W-1:0]       pulse_limit,
  input  logic [7:0]             array_data,
  output logic [7:0]             dout,
  output logic                   busy,
  output logic [NUM_SECTORS-1:0] erase_mask
);
  localparam int SUMC  = PROG_CYCLES + ERASE_CYCLES + PROT_PROG_CYCLES
                       + PROT_ERASE_CYCLES + ACCEPT_CYCLES + (1 << LIM_W);
  localparam int CNT_W = $clog2(SUMC);
  localparam logic [2:0] OP_PROG = 3'd1, OP_CHIP = 3'd2, OP_SECT = 3'd3,
                         OP_SUSP = 3'd4, OP_RES = 3'd5, OP_RST = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_FAKE, S_WIN, S_ERASE, S_SUSP, S_FAIL} st_t;

  st_t st;
  logic [CNT_W-1:0] tmr;
  logic [2:0] pcnt;
  logic tog, blank_r, fake_er, we_q, rd_q;
  logic [NUM_SECTORS-1:0] sel, em;

  wire rd_act    = !ce_n && !oe_n;
  wire rd_rise   = rd_act && !rd_q;
  wire we_rise   = !ce_n && we_n && !we_q;
  wire reset_hit = we_rise && cmd_op == OP_RST;
  wire [NUM_SECTORS-1:0] onehot = NUM_SECTORS'(1) << cmd_sector;
  wire [CNT_W-1:0] lim = CNT_W'(pulse_limit);
  wire [NUM_SECTORS-1:0] live = sel & ~prot_mask;

  assign busy       = st != S_IDLE;
  assign erase_mask = (st == S_ERASE || st == S_SUSP) ? em : '0;
  assign dout = busy ? {1'b0, tog, st == S_FAIL, 1'b0, st == S_ERASE || st == S_SUSP, 3'b000}
                     : array_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; pcnt <= '0; tog <= 1'b0; blank_r <= 1'b1;
      fake_er <= 1'b0; we_q <= 1'b1; rd_q <= 1'b0; sel <= '0; em <= '0;
    end else begin
      we_q <= we_n;
      rd_q <= rd_act;
      if (rd_rise && busy) tog <= ~tog;
      if (reset_hit) begin
        st <= S_IDLE; pcnt <= '0; sel <= '0; em <= '0; tmr <= '0;
      end else begin
        case (st)
          S_IDLE: begin
            tmr <= '0;
            if (cmd_op == 3'd0 || cmd_op == 3'd7) pcnt <= '0;
            else if (we_rise) begin
              if (cmd_op == OP_PROG && pcnt == 3'd3) begin
                pcnt <= '0;
                blank_r <= cmd_blank;
                if (prot_mask[cmd_sector]) begin st <= S_FAKE; fake_er <= 1'b0; end
                else st <= S_PROG;
              end else if (cmd_op == OP_CHIP && pcnt == 3'd5) begin
                pcnt <= '0;
                sel <= '1;
                if (&prot_mask) begin st <= S_FAKE; fake_er <= 1'b1; end
                else begin st <= S_ERASE; em <= ~prot_mask; end
              end else if (cmd_op == OP_SECT && pcnt == 3'd5) begin
                pcnt <= '0;
                sel <= onehot;
                st <= S_WIN;
              end else if (pcnt != 3'd7) pcnt <= pcnt + 3'd1;
            end
          end
          S_PROG: begin
            if (tmr == lim) st <= S_FAIL;
            else if (blank_r && tmr == CNT_W'(PROG_CYCLES - 1)) st <= S_IDLE;
            else tmr <= tmr + 1'b1;
          end
          S_FAKE: begin
            if (tmr == (fake_er ? CNT_W'(PROT_ERASE_CYCLES - 1) : CNT_W'(PROT_PROG_CYCLES - 1))) begin
              st <= S_IDLE; sel <= '0;
            end else tmr <= tmr + 1'b1;
          end
          S_WIN: begin
            if (we_rise && cmd_op == OP_SECT) begin
              sel <= sel | onehot; tmr <= '0;
            end else if (tmr == CNT_W'(ACCEPT_CYCLES - 1)) begin
              tmr <= '0;
              if (live == '0) begin st <= S_FAKE; fake_er <= 1'b1; end
              else begin st <= S_ERASE; em <= live; end
            end else tmr <= tmr + 1'b1;
          end
          S_ERASE: begin
            if (we_rise && cmd_op == OP_SUSP) st <= S_SUSP;
            else if (tmr == lim) st <= S_FAIL;
            else if (tmr == CNT_W'(ERASE_CYCLES - 1)) begin st <= S_IDLE; em <= '0; sel <= '0; end
            else tmr <= tmr + 1'b1;
          end
          S_SUSP: if (we_rise && cmd_op == OP_RES) st <= S_ERASE;
          default: st <= S_FAIL;
        endcase
      end
    end
  end

  assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_rise) |=> (tog != $past(tog)));
  assert_toggle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_rise) |=> $stable(tog));
  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FAIL && !reset_hit) |=> (st == S_FAIL && busy));
  assert_reset_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reset_hit |=> !busy);
  assert_unprot_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ERASE && $past(st) != S_ERASE && $past(st) != S_SUSP)
      |-> ((em & $past(prot_mask)) == '0));
  assert_win_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WIN) |-> (dout[3] == 1'b0 && erase_mask == '0));
endmodule

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;
  localparam int NS = 8, PC = 10, EC = 20, PPC = 6, PEC = 14, AC = 8;
  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1, cmd_blank = 1;
  logic [2:0] cmd_op = 0;
  logic [2:0] cmd_sector = 0;
  logic [NS-1:0] prot_mask = 0;
  logic [7:0] pulse_limit = 8'd200, array_data = 8'h5A;
  logic [7:0] dout;
  logic busy;
  logic [NS-1:0] erase_mask;
  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  flash_status_gen #(.NUM_SECTORS(NS), .LIM_W(8), .PROG_CYCLES(PC), .ERASE_CYCLES(EC),
    .PROT_PROG_CYCLES(PPC), .PROT_ERASE_CYCLES(PEC), .ACCEPT_CYCLES(AC)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .cmd_blank(cmd_blank), .prot_mask(prot_mask),
    .pulse_limit(pulse_limit), .array_data(array_data), .dout(dout), .busy(busy),
    .erase_mask(erase_mask));

  // behavioural reference: 0 idle 1 program 2 fake 3 window 4 erase 5 suspended 6 failed
  int m_st, m_t, m_pc;
  bit m_tog, m_blank, m_fer, m_weq, m_rdq;
  bit [NS-1:0] m_sel, m_em;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_pc = 0; m_tog = 0; m_blank = 1; m_fer = 0;
      m_weq = 1; m_rdq = 0; m_sel = 0; m_em = 0;
    end else begin
      bit wr, rd, act;
      int dur;
      wr = !ce_n && we_n && !m_weq;
      act = !ce_n && !oe_n;
      rd = act && !m_rdq;
      m_weq = we_n; m_rdq = act;
      if (rd && m_st != 0) m_tog = !m_tog;
      if (wr && cmd_op == 6) begin
        m_st = 0; m_pc = 0; m_sel = 0; m_em = 0; m_t = 0;
      end else if (m_st == 0) begin
        m_t = 0;
        if (cmd_op == 0 || cmd_op == 7) m_pc = 0;
        else if (wr) begin
          if (cmd_op == 1 && m_pc == 3) begin
            m_pc = 0; m_blank = cmd_blank;
            if (prot_mask[cmd_sector]) begin m_st = 2; m_fer = 0; end else m_st = 1;
          end else if ((cmd_op == 2 || cmd_op == 3) && m_pc == 5) begin
            m_pc = 0;
            m_sel = (cmd_op == 2) ? '1 : (NS'(1) << cmd_sector);
            if (cmd_op == 3) m_st = 3;
            else if ((m_sel & ~prot_mask) == 0) begin m_st = 2; m_fer = 1; end
            else begin m_st = 4; m_em = m_sel & ~prot_mask; end
          end else if (m_pc < 7) m_pc++;
        end
      end else if (m_st == 1) begin
        if (m_t == pulse_limit) m_st = 6;
        else if (m_blank && m_t == PC - 1) m_st = 0;
        else m_t++;
      end else if (m_st == 2) begin
        dur = m_fer ? PEC : PPC;
        if (m_t == dur - 1) begin m_st = 0; m_sel = 0; end else m_t++;
      end else if (m_st == 3) begin
        if (wr && cmd_op == 3) begin m_sel |= NS'(1) << cmd_sector; m_t = 0; end
        else if (m_t == AC - 1) begin
          m_t = 0;
          if ((m_sel & ~prot_mask) == 0) begin m_st = 2; m_fer = 1; end
          else begin m_st = 4; m_em = m_sel & ~prot_mask; end
        end else m_t++;
      end else if (m_st == 4) begin
        if (wr && cmd_op == 4) m_st = 5;
        else if (m_t == pulse_limit) m_st = 6;
        else if (m_t == EC - 1) begin m_st = 0; m_em = 0; m_sel = 0; end
        else m_t++;
      end else if (m_st == 5) begin
        if (wr && cmd_op == 5) m_st = 4;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] ed;
      ed = (m_st != 0) ? {1'b0, m_tog, m_st == 6, 1'b0, m_st == 4 || m_st == 5, 3'b000} : array_data;
      chk(dout === ed, cur_req, dout, ed);
      chk(busy === (m_st != 0), cur_req, busy, m_st != 0);
      chk(erase_mask === ((m_st == 4 || m_st == 5) ? m_em : '0), cur_req, erase_mask, m_em);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr_seq(input logic [2:0] op, input logic [2:0] sec, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cmd_op = op; cmd_sector = sec; we_n = 0;
      @(negedge clk); we_n = 1;
      @(negedge clk);
    end
  endtask

  task automatic op_none(); @(negedge clk); cmd_op = 0; endtask
  task automatic wait_cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic rd_oe(output logic [7:0] v);
    @(negedge clk); oe_n = 0;
    @(negedge clk); v = dout; oe_n = 1;
  endtask

  initial begin
    logic [7:0] a, b;
    ce_n = 0;
    wait_cyc(3);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(!busy && erase_mask == 0, "R1", {busy, erase_mask}, 0);
    chk(dout == 8'h5A, "R5", dout, 8'h5A);
    array_data = 8'hC3; #1;
    chk(dout == 8'hC3, "R5", dout, 8'hC3);

    cur_req = "R2";
    wr_seq(3'd1, 3'd2, 3);
    chk(!busy, "R2", busy, 0);
    wr_seq(3'd1, 3'd2, 1);
    chk(busy, "R2", busy, 1);
    op_none();
    cur_req = "R4";
    rd_oe(a); rd_oe(b);
    chk(a[6] != b[6], "R4", b[6], !a[6]);
    chk((b & 8'h97) == 0, "R6", b, b & 8'h68);
    wait_cyc(3);
    chk(dout[6] == b[6], "R4", dout[6], b[6]);
    wait_cyc(PC);
    chk(!busy && dout == 8'hC3, "R2", dout, 8'hC3);

    cur_req = "R4";
    wr_seq(3'd1, 3'd0, 4); op_none();
    a = dout;
    @(negedge clk); ce_n = 1; oe_n = 0;
    @(negedge clk); ce_n = 0;
    @(negedge clk); b = dout; ce_n = 0; oe_n = 1;
    chk(a[6] != b[6], "R4", b[6], !a[6]);
    wait_cyc(PC + 2);

    cur_req = "R7";
    prot_mask = 8'h04;
    wr_seq(3'd1, 3'd2, 4); op_none();
    chk(busy && !dout[5], "R7", dout, 8'h00);
    wait_cyc(PPC);
    chk(!busy && dout == 8'hC3, "R7", dout, 8'hC3);

    cur_req = "R3";
    prot_mask = 8'h0F;
    wr_seq(3'd2, 3'd0, 5);
    chk(!busy, "R3", busy, 0);
    wr_seq(3'd2, 3'd0, 1); op_none();
    cur_req = "R8";
    chk(busy && erase_mask == 8'hF0, "R8", erase_mask, 8'hF0);
    chk(dout[3], "R10", dout[3], 1);
    cur_req = "R11";
    wr_seq(3'd4, 3'd0, 1); op_none();
    wait_cyc(EC + 5);
    chk(busy && erase_mask == 8'hF0, "R11", {busy, erase_mask}, {1'b1, 8'hF0});
    rd_oe(a); rd_oe(b);
    chk(a[6] != b[6], "R11", b[6], !a[6]);
    wr_seq(3'd5, 3'd0, 1); op_none();
    chk(busy, "R11", busy, 1);
    wait_cyc(EC + 2);
    chk(!busy, "R11", busy, 0);

    cur_req = "R10";
    prot_mask = 8'h04;
    wr_seq(3'd3, 3'd1, 6);
    chk(busy && !dout[3] && erase_mask == 0, "R10", dout, 8'h00);
    wr_seq(3'd3, 3'd5, 1);
    wr_seq(3'd3, 3'd2, 1); op_none();
    wait_cyc(AC);
    chk(dout[3] && erase_mask == 8'h22, "R10", erase_mask, 8'h22);
    wr_seq(3'd3, 3'd6, 1); op_none();
    chk(erase_mask == 8'h22, "R10", erase_mask, 8'h22);
    wait_cyc(EC + 2);

    cur_req = "R8";
    prot_mask = 8'h08;
    wr_seq(3'd3, 3'd3, 6); op_none();
    wait_cyc(AC + 1);
    chk(busy && erase_mask == 0 && !dout[3], "R8", {busy, erase_mask}, 9'h100);
    wait_cyc(PEC + 1);
    chk(!busy && dout == 8'hC3, "R8", dout, 8'hC3);

    cur_req = "R9";
    prot_mask = 0; cmd_blank = 0; pulse_limit = 8'd5;
    wr_seq(3'd1, 3'd0, 4); op_none();
    wait_cyc(10);
    chk(busy && dout[5], "R9", dout, 8'h20);
    wait_cyc(30);
    rd_oe(a); rd_oe(b);
    chk(busy && b[5] && a[6] != b[6], "R9", b, a ^ 8'h40);
    cur_req = "R12";
    wr_seq(3'd6, 3'd0, 1); op_none();
    chk(!busy && dout == 8'hC3, "R12", dout, 8'hC3);

    cur_req = "R12";
    cmd_blank = 1; pulse_limit = 8'd200;
    wr_seq(3'd3, 3'd0, 6);
    wr_seq(3'd6, 3'd0, 1); op_none();
    chk(!busy && erase_mask == 0, "R12", busy, 0);
    wait_cyc(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule